// File: doc/BRIEF.md
# Exception Control Register Block

This block holds the privilege and exception state of a processor core. A status register keeps a three-level stack of (privilege, interrupt-enable) pairs and a per-source interrupt mask. Beside it sit a cause register, an exception return address and a faulting-address register. When the pipeline raises an exception, the block pushes the mode stack, which drops the core into kernel mode with interrupts off. In the same cycle it records the code, the instruction address and, when one is supplied, the memory address that faulted. A return strobe pops the stack again.

Software reaches the registers through a small indexed read/write port. The port only works in kernel mode. An access from user mode returns zero, changes nothing and raises a one-cycle privilege-fault pulse, which the pipeline can turn into an exception. The block also merges the pending-interrupt inputs with the mask and the current enable bit into one registered interrupt request. Exception requests are never masked.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero. This means kernel mode, interrupts disabled and mask clear. `irq_req`, `priv_fault` and `rd_data` are 0 and `in_kernel` is 1.
- R2: Status bits 5:0 hold three pairs: current in 1:0, previous in 3:2, oldest in 5:4. In each pair, bit 1 is the privilege bit (1 = user, 0 = kernel) and bit 0 is the enable bit (1 = interrupts on). `in_kernel` is the inverse of status bit 1.
- R3: An exception request is accepted whatever the enable bit holds. On the next edge, status bits 5:0 become their old value shifted left by two with bits 1:0 cleared. The mask is unchanged.
- R4: A return strobe sets status bits 5:0 to {s[5:4], s[5:2]}, so the oldest pair stays where it was.
- R5: An exception loads the return-address register from `exc_pc` and puts `exc_code` in cause bits 6:2. It loads the faulting-address register from `exc_addr` only when `exc_addr_vld` is 1; otherwise that register keeps its value.
- R6: The register indices are 8 (faulting address), 12 (status), 13 (cause) and 14 (return address). Any other index reads 0. A read returns its data on `rd_data` one cycle later. Status reads the mask in bits 15:8 and the stack in bits 5:0. Cause reads the live `irq_pend` inputs in bits 15:8. All other bits read 0.
- R7: In kernel mode, a write updates status (bits 15:8 and 5:0 only), the return-address register or the faulting-address register. A write to cause has no effect.
- R8: When status bit 1 is 1, a read returns 0 and a write changes no register. Either access sets `priv_fault` for exactly the following cycle.
- R9: `irq_req` in cycle t+1 equals status bit 0 ANDed with the OR of (`irq_pend` AND mask) in cycle t.
- R10: An exception cancels any register write in its cycle. For status, exception beats write, and write beats return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception entry request |
| exc_code | input | CAUSE_W | Cause code of the exception |
| exc_pc | input | XLEN | Address of the affected instruction |
| exc_addr | input | XLEN | Faulting memory address |
| exc_addr_vld | input | 1 | exc_addr is meaningful for this exception |
| eret | input | 1 | Return-from-exception strobe |
| reg_rd | input | 1 | Register read request |
| reg_wr | input | 1 | Register write request |
| reg_idx | input | 5 | Register index |
| reg_wdata | input | XLEN | Write data |
| irq_pend | input | NIRQ | Pending interrupt sources |
| rd_data | output | XLEN | Registered read data |
| priv_fault | output | 1 | Access attempted from user mode |
| irq_req | output | 1 | Registered interrupt request |
| in_kernel | output | 1 | Core is in kernel mode |

## Verification
The collision that matters most is an exception entry landing in the same cycle as a software write to status, or as a return strobe. Each of these shifts the same six bits. The bench drives these pairs together, and also a write paired with a return, and an exception paired with a write to the return-address register. It then reads the registers back and compares them with a model that applies the stated priority to the pre-cycle state. It repeats the same collisions in user mode, where the write must vanish while the push and the fault pulse still happen.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int          IDX_W     = 5;
  localparam logic [4:0]  IDX_BAD   = 5'd8;
  localparam logic [4:0]  IDX_STAT  = 5'd12;
  localparam logic [4:0]  IDX_CAUSE = 5'd13;
  localparam logic [4:0]  IDX_EPC   = 5'd14;
  localparam int          STK_W     = 6;

  // entry: older pairs move up, fresh pair is kernel with interrupts off
  function automatic logic [STK_W-1:0] stk_push(input logic [STK_W-1:0] s);
    return {s[3:0], 2'b00};
  endfunction

  // return: oldest pair is duplicated, previous becomes current
  function automatic logic [STK_W-1:0] stk_pop(input logic [STK_W-1:0] s);
    return {s[5:4], s[5:2]};
  endfunction

endpackage

// File: rtl/exc_mode_stack.sv
module exc_mode_stack
  import exc_pkg::*;
#(
  parameter int NIRQ = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             wr_en,
  input  logic [NIRQ-1:0]  wr_mask,
  input  logic [STK_W-1:0] wr_stk,
  output logic [STK_W-1:0] stk,
  output logic [NIRQ-1:0]  mask
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stk  <= '0;
      mask <= '0;
    end else if (push) begin
      stk <= stk_push(stk);
    end else if (wr_en) begin
      stk  <= wr_stk;
      mask <= wr_mask;
    end else if (pop) begin
      stk <= stk_pop(stk);
    end
  end

  // R3: entry leaves kernel mode, interrupts off, older pairs shifted
  p_push_kernel_r3: assert property (@(posedge clk) disable iff (rst)
    push |=> (stk[1:0] == 2'b00) && (stk[5:2] == $past(stk[3:0])));

  // R3: mask untouched by entry
  p_push_mask_r3: assert property (@(posedge clk) disable iff (rst)
    push |=> $stable(mask));

  // R4: lone return keeps oldest pair and shifts down
  p_pop_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !wr_en) |=>
      (stk[5:4] == $past(stk[5:4])) && (stk[3:0] == $past(stk[5:2])));

endmodule

// File: rtl/exc_capture.sv
module exc_capture #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exc_req,
  input  logic [CAUSE_W-1:0] exc_code,
  input  logic [XLEN-1:0]    exc_pc,
  input  logic [XLEN-1:0]    exc_addr,
  input  logic               exc_addr_vld,
  input  logic               wr_epc,
  input  logic               wr_bad,
  input  logic [XLEN-1:0]    wdata,
  output logic [CAUSE_W-1:0] code_q,
  output logic [XLEN-1:0]    epc_q,
  output logic [XLEN-1:0]    bad_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      epc_q  <= '0;
    end else if (exc_req) begin
      code_q <= exc_code;
      epc_q  <= exc_pc;
    end else if (wr_epc) begin
      epc_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_q <= '0;
    end else if (exc_req) begin
      if (exc_addr_vld) bad_q <= exc_addr;
    end else if (wr_bad) begin
      bad_q <= wdata;
    end
  end

  // R5: return address captured on entry
  p_epc_capture_r5: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> (epc_q == $past(exc_pc)) && (code_q == $past(exc_code)));

  // R5: faulting address kept when not flagged valid
  p_bad_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (exc_req && !exc_addr_vld) |=> $stable(bad_q));

endmodule

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ie,
  input  logic [NIRQ-1:0] mask,
  input  logic [NIRQ-1:0] pend,
  output logic            irq_req
);

  logic hit;
  assign hit = |(pend & mask);

  always_ff @(posedge clk) begin
    if (rst) irq_req <= 1'b0;
    else     irq_req <= ie & hit;
  end

  // R9: disabled interrupts never raise a request
  p_irq_off_r9: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq_req);

  // R9: no enabled pending source, no request
  p_irq_nosrc_r9: assert property (@(posedge clk) disable iff (rst)
    ((pend & mask) == '0) |=> !irq_req);

endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
  import exc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5,
  parameter int NIRQ    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exc_req,
  input  logic [CAUSE_W-1:0] exc_code,
  input  logic [XLEN-1:0]    exc_pc,
  input  logic [XLEN-1:0]    exc_addr,
  input  logic               exc_addr_vld,
  input  logic               eret,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [IDX_W-1:0]   reg_idx,
  input  logic [XLEN-1:0]    reg_wdata,
  input  logic [NIRQ-1:0]    irq_pend,
  output logic [XLEN-1:0]    rd_data,
  output logic               priv_fault,
  output logic               irq_req,
  output logic               in_kernel
);

  localparam int MASK_LSB = 8;
  localparam int CODE_LSB = 2;

  logic [STK_W-1:0]   stk;
  logic [NIRQ-1:0]    mask;
  logic [CAUSE_W-1:0] code_q;
  logic [XLEN-1:0]    epc_q;
  logic [XLEN-1:0]    bad_q;
  logic               user_m;
  logic               wr_ok;
  logic               wr_stat;
  logic               wr_epc;
  logic               wr_bad;
  logic [XLEN-1:0]    stat_word;
  logic [XLEN-1:0]    cause_word;
  logic               unused_wbits;

  assign user_m  = stk[1];
  assign wr_ok   = reg_wr & ~user_m & ~exc_req;
  assign wr_stat = wr_ok & (reg_idx == IDX_STAT);
  assign wr_epc  = wr_ok & (reg_idx == IDX_EPC);
  assign wr_bad  = wr_ok & (reg_idx == IDX_BAD);
  assign unused_wbits = ^{reg_wdata[7:6], reg_wdata[XLEN-1:MASK_LSB+NIRQ]};

  exc_mode_stack #(.NIRQ(NIRQ)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push    (exc_req),
    .pop     (eret),
    .wr_en   (wr_stat),
    .wr_mask (reg_wdata[MASK_LSB +: NIRQ]),
    .wr_stk  (reg_wdata[STK_W-1:0]),
    .stk     (stk),
    .mask    (mask)
  );

  exc_capture #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_capture (
    .clk          (clk),
    .rst          (rst),
    .exc_req      (exc_req),
    .exc_code     (exc_code),
    .exc_pc       (exc_pc),
    .exc_addr     (exc_addr),
    .exc_addr_vld (exc_addr_vld),
    .wr_epc       (wr_epc),
    .wr_bad       (wr_bad),
    .wdata        (reg_wdata),
    .code_q       (code_q),
    .epc_q        (epc_q),
    .bad_q        (bad_q)
  );

  exc_irq_gate #(.NIRQ(NIRQ)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .ie      (stk[0]),
    .mask    (mask),
    .pend    (irq_pend),
    .irq_req (irq_req)
  );

  always_comb begin
    stat_word = '0;
    stat_word[STK_W-1:0]         = stk;
    stat_word[MASK_LSB +: NIRQ]  = mask;
    cause_word = '0;
    cause_word[CODE_LSB +: CAUSE_W] = code_q;
    cause_word[MASK_LSB +: NIRQ]    = irq_pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (reg_rd) begin
      if (user_m) begin
        rd_data <= '0;
      end else begin
        case (reg_idx)
          IDX_STAT:  rd_data <= stat_word;
          IDX_CAUSE: rd_data <= cause_word;
          IDX_EPC:   rd_data <= epc_q;
          IDX_BAD:   rd_data <= bad_q;
          default:   rd_data <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) priv_fault <= 1'b0;
    else     priv_fault <= (reg_rd | reg_wr) & user_m;
  end

  assign in_kernel = ~stk[1];

  // R8: user access flags a fault next cycle
  p_user_fault_r8: assert property (@(posedge clk) disable iff (rst)
    ((reg_rd || reg_wr) && stk[1]) |=> priv_fault);

  // R8: user read yields zero
  p_user_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && stk[1]) |=> (rd_data == '0));

  // R8: user write alone leaves status alone
  p_user_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && stk[1] && !exc_req && !eret) |=> ($stable(stk) && $stable(mask)));

  // R10: exception wins over a simultaneous return
  p_exc_over_ret_r10: assert property (@(posedge clk) disable iff (rst)
    (exc_req && eret) |=> (stk[1:0] == 2'b00));

endmodule

// File: tb/sim_exc_ctrl_regs.sv
`timescale 1ns/1ps
module sim_exc_ctrl_regs;

  localparam int XLEN = 32;
  localparam int CW   = 5;
  localparam int NI   = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            exc_req = 0, exc_addr_vld = 0, eret = 0, reg_rd = 0, reg_wr = 0;
  logic [CW-1:0]   exc_code = '0;
  logic [XLEN-1:0] exc_pc = '0, exc_addr = '0, reg_wdata = '0;
  logic [4:0]      reg_idx = '0;
  logic [NI-1:0]   irq_pend = '0;
  logic [XLEN-1:0] rd_data;
  logic            priv_fault, irq_req, in_kernel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [5:0]      m_stk  = '0;
  logic [7:0]      m_mask = '0;
  logic [4:0]      m_code = '0;
  logic [31:0]     m_epc  = '0;
  logic [31:0]     m_bad  = '0;

  always #4 clk = ~clk;

  exc_ctrl_regs #(.XLEN(XLEN), .CAUSE_W(CW), .NIRQ(NI)) u0 (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code), .exc_pc(exc_pc),
    .exc_addr(exc_addr), .exc_addr_vld(exc_addr_vld), .eret(eret), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .irq_pend(irq_pend),
    .rd_data(rd_data), .priv_fault(priv_fault), .irq_req(irq_req), .in_kernel(in_kernel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] mval(input logic [4:0] idx);
    case (idx)
      5'd12:   return {16'h0, m_mask, 2'b00, m_stk};
      5'd13:   return {16'h0, irq_pend, 1'b0, m_code, 2'b00};
      5'd14:   return m_epc;
      5'd8:    return m_bad;
      default: return 32'h0;
    endcase
  endfunction

  // one cycle with any mix of operations; model applies stated priority (R10)
  task automatic step(input bit e, input bit r, input bit w, input bit rq,
                      input logic [4:0] idx, input logic [31:0] wd,
                      input logic [4:0] code, input logic [31:0] pc,
                      input logic [31:0] addr, input bit av, input string req);
    bit user, wok, stat_w;
    logic [31:0] exp_rd;
    user   = m_stk[1];
    exp_rd = user ? 32'h0 : mval(idx);
    exc_req = e; eret = r; reg_wr = w; reg_rd = rq; reg_idx = idx; reg_wdata = wd;
    exc_code = code; exc_pc = pc; exc_addr = addr; exc_addr_vld = av;
    tick();
    exc_req = 0; eret = 0; reg_wr = 0; reg_rd = 0; exc_addr_vld = 0;
    wok    = w && !user && !e;
    stat_w = wok && idx == 5'd12;
    if (e) begin
      m_code = code; m_epc = pc;
      if (av) m_bad = addr;
      m_stk = {m_stk[3:0], 2'b00};
    end else if (stat_w) begin
      m_stk = wd[5:0]; m_mask = wd[15:8];
    end else if (r) begin
      m_stk = {m_stk[5:4], m_stk[5:2]};
    end
    if (wok && idx == 5'd14) m_epc = wd;
    if (wok && idx == 5'd8)  m_bad = wd;
    chk({req, " R8 fault"}, {31'h0, priv_fault}, {31'h0, user && (w || rq)});
    chk({req, " R2 in_kernel"}, {31'h0, in_kernel}, {31'h0, !m_stk[1]});
    if (rq) chk({req, " R6 rd_data"}, rd_data, exp_rd);
  endtask

  task automatic rd(input logic [4:0] idx, input string req);
    step(0, 0, 0, 1, idx, 0, 0, 0, 0, 0, req);
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] d, input string req);
    step(0, 0, 1, 0, idx, d, 0, 0, 0, 0, req);
  endtask

  task automatic take_exc(input logic [4:0] c, input logic [31:0] pc,
                          input logic [31:0] a, input bit av, input string req);
    step(1, 0, 0, 0, 0, 0, c, pc, a, av, req);
  endtask

  task automatic to_kernel;
    if (m_stk[1]) take_exc(5'd1, 32'h0, 32'h0, 0, "R3 regain");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    // R1 reset state
    chk("R1 in_kernel", {31'h0, in_kernel}, 32'h1);
    chk("R1 irq_req", {31'h0, irq_req}, 32'h0);
    chk("R1 priv_fault", {31'h0, priv_fault}, 32'h0);
    chk("R1 rd_data", rd_data, 32'h0);
    rst = 0;
    rd(5'd12, "R1 status"); rd(5'd13, "R1 cause");
    rd(5'd14, "R1 epc");    rd(5'd8,  "R1 bad");
    // R6 unmapped indices
    rd(5'd0, "R6 idx0"); rd(5'd9, "R6 idx9"); rd(5'd31, "R6 idx31");
    // R7 kernel writes; cause write ignored
    wr(5'd14, 32'hDEAD_BEE0, "R7 epc"); rd(5'd14, "R7 epc");
    wr(5'd8,  32'h1234_5678, "R7 bad"); rd(5'd8,  "R7 bad");
    wr(5'd13, 32'hFFFF_FFFF, "R7 cause"); rd(5'd13, "R7 cause ignored");
    wr(5'd12, 32'hFFFF_FFC0 | 32'h0000_0005, "R7 status bits"); rd(5'd12, "R7 status");

    // R2/R3/R4/R5/R8 sweep over every stack value
    for (int v = 0; v < 64; v++) begin
      to_kernel();
      wr(5'd12, {16'h0, 8'(v * 37), 2'b00, 6'(v)}, "R2 sweep write");
      rd(5'd12, "R2 sweep read");
      wr(5'd14, 32'hAAAA_0000, "R8 sweep write");
      take_exc(5'(v), 32'h1000 + v * 4, 32'h8000_0000 + v, v[0], "R3 sweep entry");
      rd(5'd12, "R3 pushed status");
      rd(5'd13, "R5 cause");
      rd(5'd14, "R5 epc");
      rd(5'd8,  "R5 bad");
      step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R4 return");
      rd(5'd12, "R4 popped status");
    end

    // R9 interrupt gate, every mask against every single source
    to_kernel();
    for (int m = 0; m < 256; m++) begin
      wr(5'd12, {16'h0, 8'(m), 8'h01}, "R9 set mask");
      for (int b = 0; b < 8; b++) begin
        irq_pend = 8'(1 << b);
        tick();
        chk("R9 irq", {31'h0, irq_req}, {31'h0, 1'(m >> b)});
      end
    end
    wr(5'd12, {16'h0, 8'hFF, 8'h00}, "R9 ie off");
    irq_pend = 8'hFF;
    tick();
    chk("R9 irq ie=0", {31'h0, irq_req}, 32'h0);
    rd(5'd13, "R6 cause pending");
    irq_pend = 8'h00;

    // R10 collisions, kernel mode
    wr(5'd12, {16'h0, 8'h3C, 8'h1D}, "R10 setup");
    step(1, 0, 1, 0, 5'd12, 32'h0000_FF3F, 5'd4, 32'h400, 0, 0, "R10 exc+wr stat");
    rd(5'd12, "R10 exc+wr stat");
    step(1, 1, 0, 0, 0, 0, 5'd6, 32'h404, 0, 0, "R10 exc+ret");
    rd(5'd12, "R10 exc+ret");
    step(0, 1, 1, 0, 5'd12, 32'h0000_5A2C, 0, 0, 0, 0, "R10 wr+ret");
    rd(5'd12, "R10 wr+ret");
    step(0, 1, 1, 0, 5'd14, 32'h0000_7770, 0, 0, 0, 0, "R10 wr epc+ret");
    rd(5'd14, "R10 wr epc+ret");
    to_kernel();
    step(1, 0, 1, 0, 5'd14, 32'h0000_1111, 5'd2, 32'h0000_2220, 0, 0, "R10 exc+wr epc");
    rd(5'd14, "R10 exc+wr epc");
    // R10/R8 collisions in user mode
    wr(5'd12, {16'h0, 8'h81, 8'h37}, "R8 enter user");
    wr(5'd12, 32'h0, "R8 user write");
    step(1, 0, 1, 0, 5'd12, 32'h0, 5'd9, 32'h900, 32'h55, 1, "R10 user exc+wr");
    rd(5'd12, "R10 user exc+wr");
    rd(5'd8,  "R5 bad after user exc");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule